// File: doc/BRIEF.md
# Arithmetic/Logic Unit with Flag Register

This block computes one data operation per cycle on an accumulator operand A and a second operand B. It also keeps a status register whose low flags record the outcome of the last flag-affecting operation. The result is combinational. The arithmetic flags are written on a clock edge only when the caller marks the cycle as an executed instruction. Software can overwrite the arithmetic flags directly through a narrow write port.

Two further bits track power state: a power-down flag and a watchdog-expiry flag. Software writes cannot reach them. They move only on four system strobes: power-up, watchdog clear, halt entry and watchdog expiry. The carry held in the register feeds the carry-using operations of the next cycle, so chained multi-byte arithmetic works without outside help.

Top module: `alu_status_unit`

## Requirements
- R1: The status output places C at bit 0, AC at bit 1, Z at bit 2, OV at bit 3, the power-down flag at bit 4 and the expiry flag at bit 5. Bits 6 and 7 always read 0, and every bit is 0 while reset is asserted and after it is released.
- R2: Opcode 0 (add) returns A+B and opcode 1 (add with carry) returns A+B+C. Both set C from the carry out of the top bit and AC from the carry out of bit 3.
- R3: Opcode 2 (subtract) returns A−B and opcode 3 (subtract with carry) returns A−B−(1−C). Both set C to 1 exactly when no borrow occurs, and AC to 1 exactly when the low nibble needs no borrow.
- R4: For opcodes 0 to 3, OV is set when the carry into the top bit differs from the carry out of it, and Z is set when the result is zero.
- R5: Opcode 4 decimal-adjusts A. A nibble gets 6 added when it exceeds 9 or when its flag is set (AC for the low nibble, C for the high nibble), and the carry from the low-nibble correction ripples into the high nibble. C is then set if the high nibble overflows and is otherwise kept. No other flag changes.
- R6: Opcodes 5 (AND), 6 (OR), 7 (XOR), 8 (complement of A), 13 (A+1) and 14 (A−1) update only Z.
- R7: Opcodes 9 and 10 rotate A left and right without touching any flag. Opcodes 11 and 12 rotate A left and right through C and update only C. Opcode 15 passes A through and changes no flag.
- R8: The flags change only on a clock edge where the execute input is high. The result output follows its inputs combinationally.
- R9: A software write loads bits 3:0 of the status register from the write data, takes priority over an execute in the same cycle, and never changes the power-down or expiry flag.
- R10: The power-down flag is set by the halt strobe and cleared by the watchdog-clear strobe. When both strobes arrive together, the clear wins.
- R11: The expiry flag is set by the expiry strobe and cleared by either the halt strobe or the watchdog-clear strobe. When setting and clearing strobes arrive together, the set wins.
- R12: The power-up strobe clears both power flags regardless of any other strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| exec_i | input | 1 | Commit the flags of the current operation |
| op_i | input | 4 | Operation code |
| a_i | input | W | Accumulator operand |
| b_i | input | W | Second operand |
| res_o | output | W | Operation result |
| status_o | output | 8 | Status register |
| sw_wr_i | input | 1 | Software write strobe for the arithmetic flags |
| sw_flags_i | input | 4 | Write data for C, AC, Z, OV |
| pwrup_i | input | 1 | Power-up event strobe |
| clrwdt_i | input | 1 | Watchdog clear event strobe |
| halt_i | input | 1 | Halt entry event strobe |
| wdto_i | input | 1 | Watchdog expiry event strobe |

## Verification
The bench builds the block with W = 8, the smallest width that holds two BCD digits. At that width every value of A can be swept for each operation. Add and subtract see every A against 32 spread values of B, with both settings of the incoming carry, so every carry, nibble-borrow and signed-overflow case is reached. The decimal adjust sees every A under all four C/AC combinations. Each operation starts from a flag pattern written through the software port, so flags that must survive are shown to survive. The power flags are driven through each single strobe and each conflicting pair of strobes.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int STAT_W = 8;
  localparam int ARF_W  = 4;

  localparam int F_C   = 0;
  localparam int F_AC  = 1;
  localparam int F_Z   = 2;
  localparam int F_OV  = 3;
  localparam int F_PDN = 4;
  localparam int F_EXP = 5;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_DADJ = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_CPL  = 4'd8,
    OP_ROL  = 4'd9,
    OP_ROR  = 4'd10,
    OP_ROLC = 4'd11,
    OP_RORC = 4'd12,
    OP_INC  = 4'd13,
    OP_DEC  = 4'd14,
    OP_PASS = 4'd15
  } alu_op_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         c_o,
  output logic         ac_o,
  output logic         ov_o
);

  logic [W-1:0] bx;
  logic [W:0]   full;
  logic [W-1:0] low_part;
  logic [4:0]   nib0;

  always_comb begin
    bx       = sub_i ? ~b_i : b_i;
    full     = {1'b0, a_i} + {1'b0, bx} + {{W{1'b0}}, cin_i};
    low_part = {1'b0, a_i[W-2:0]} + {1'b0, bx[W-2:0]} + {{(W-1){1'b0}}, cin_i};
    nib0     = {1'b0, a_i[3:0]} + {1'b0, bx[3:0]} + {4'b0, cin_i};
    sum_o    = full[W-1:0];
    c_o      = full[W];
    ac_o     = nib0[4];
    ov_o     = low_part[W-1] ^ full[W];
  end

  // Signed overflow seen from operand and result signs
  assert_ov_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ov_o == ((a_i[W-1] == bx[W-1]) && (sum_o[W-1] != a_i[W-1])));

  // Plain subtraction: carry means A did not fall below B
  assert_sub_noborrow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_i && cin_i) |-> (c_o == (a_i >= b_i)));

endmodule

// File: rtl/alu_decadj.sv
module alu_decadj #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic         c_i,
  input  logic         ac_i,
  output logic [W-1:0] res_o,
  output logic         c_o
);

  localparam int NIB = W / 4;

  logic [4:0] nib;
  logic       cy;
  logic       fix;

  always_comb begin
    cy    = 1'b0;
    nib   = 5'd0;
    fix   = 1'b0;
    res_o = a_i;
    for (int i = 0; i < NIB; i++) begin
      nib = {1'b0, a_i[4*i +: 4]} + {4'b0, cy};
      fix = (nib > 5'd9) || ((i == 0) && ac_i) || ((i == NIB - 1) && c_i);
      if (fix) nib = nib + 5'd6;
      res_o[4*i +: 4] = nib[3:0];
      cy = nib[4];
    end
    c_o = cy | c_i;
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       op_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic             c_i,
  input  logic             ac_i,
  output logic [W-1:0]     res_o,
  output logic [ARF_W-1:0] flg_o,
  output logic [ARF_W-1:0] upd_o
);

  alu_op_e      op;
  logic         as_sub;
  logic         as_cin;
  logic [W-1:0] as_sum;
  logic         as_c;
  logic         as_ac;
  logic         as_ov;
  logic [W-1:0] da_res;
  logic         da_c;

  assign op     = alu_op_e'(op_i);
  assign as_sub = op_i[1];
  assign as_cin = op_i[0] ? c_i : op_i[1];

  alu_addsub #(.W(W)) u_addsub (
    .clk   (clk),
    .rst_n (rst_n),
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (as_sub),
    .cin_i (as_cin),
    .sum_o (as_sum),
    .c_o   (as_c),
    .ac_o  (as_ac),
    .ov_o  (as_ov)
  );

  alu_decadj #(.W(W)) u_decadj (
    .a_i   (a_i),
    .c_i   (c_i),
    .ac_i  (ac_i),
    .res_o (da_res),
    .c_o   (da_c)
  );

  always_comb begin
    res_o = a_i;
    flg_o = '0;
    upd_o = '0;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
        res_o       = as_sum;
        flg_o[F_C]  = as_c;
        flg_o[F_AC] = as_ac;
        flg_o[F_OV] = as_ov;
        upd_o       = 4'b1111;
      end
      OP_DADJ: begin
        res_o      = da_res;
        flg_o[F_C] = da_c;
        upd_o[F_C] = 1'b1;
      end
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_CPL:  res_o = ~a_i;
      OP_INC:  res_o = a_i + {{(W-1){1'b0}}, 1'b1};
      OP_DEC:  res_o = a_i - {{(W-1){1'b0}}, 1'b1};
      OP_ROL:  res_o = {a_i[W-2:0], a_i[W-1]};
      OP_ROR:  res_o = {a_i[0], a_i[W-1:1]};
      OP_ROLC: begin
        res_o      = {a_i[W-2:0], c_i};
        flg_o[F_C] = a_i[W-1];
        upd_o[F_C] = 1'b1;
      end
      OP_RORC: begin
        res_o      = {c_i, a_i[W-1:1]};
        flg_o[F_C] = a_i[0];
        upd_o[F_C] = 1'b1;
      end
      default: res_o = a_i;
    endcase
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_AND, OP_OR, OP_XOR,
      OP_CPL, OP_INC, OP_DEC: upd_o[F_Z] = 1'b1;
      default: upd_o[F_Z] = upd_o[F_Z];
    endcase
    flg_o[F_Z] = (res_o == '0);
  end

  // Plain rotates and pass never request a flag update
  assert_rot_noflag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd9 || op_i == 4'd10 || op_i == 4'd15) |-> (upd_o == '0));

endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg
  import alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_i,
  input  logic [ARF_W-1:0]  flg_i,
  input  logic [ARF_W-1:0]  upd_i,
  input  logic              sw_wr_i,
  input  logic [ARF_W-1:0]  sw_flags_i,
  input  logic              pwrup_i,
  input  logic              clrwdt_i,
  input  logic              halt_i,
  input  logic              wdto_i,
  output logic [STAT_W-1:0] status_o
);

  logic [ARF_W-1:0] ar_q, ar_n;
  logic             pdn_q, pdn_n;
  logic             exp_q, exp_n;
  logic             ar_en, pw_en;

  always_comb begin
    ar_en = sw_wr_i | exec_i;
    ar_n  = ar_q;
    if (sw_wr_i) begin
      ar_n = sw_flags_i;
    end else begin
      for (int i = 0; i < ARF_W; i++) begin
        if (upd_i[i]) ar_n[i] = flg_i[i];
      end
    end
  end

  always_comb begin
    pw_en = pwrup_i | clrwdt_i | halt_i | wdto_i;
    pdn_n = pdn_q;
    exp_n = exp_q;
    if (pwrup_i) begin
      pdn_n = 1'b0;
      exp_n = 1'b0;
    end else begin
      if (clrwdt_i)    pdn_n = 1'b0;
      else if (halt_i) pdn_n = 1'b1;
      if (wdto_i)                 exp_n = 1'b1;
      else if (clrwdt_i | halt_i) exp_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ar_q <= '0;
    else if (ar_en) ar_q <= ar_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdn_q <= 1'b0;
      exp_q <= 1'b0;
    end else if (pw_en) begin
      pdn_q <= pdn_n;
      exp_q <= exp_n;
    end
  end

  assign status_o = {2'b00, exp_q, pdn_q, ar_q};

  assert_pwrup_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    pwrup_i |=> (!pdn_q && !exp_q));

  assert_expiry_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wdto_i && !pwrup_i) |=> exp_q);

  assert_halt_sets_pdn_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_i && !clrwdt_i && !pwrup_i) |=> pdn_q);

  assert_sw_keeps_power_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_i && !pw_en) |=> (pdn_q == $past(pdn_q) && exp_q == $past(exp_q)));

  assert_sw_loads_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_i |=> (status_o[3:0] == $past(sw_flags_i)));

  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr_i && !exec_i) |=> $stable(status_o[3:0]));

endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_i,
  input  logic [3:0]        op_i,
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  output logic [W-1:0]      res_o,
  output logic [STAT_W-1:0] status_o,
  input  logic              sw_wr_i,
  input  logic [ARF_W-1:0]  sw_flags_i,
  input  logic              pwrup_i,
  input  logic              clrwdt_i,
  input  logic              halt_i,
  input  logic              wdto_i
);

  logic             rst_meta_q;
  logic             rst_sync_q;
  logic [ARF_W-1:0] flg;
  logic [ARF_W-1:0] upd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  alu_core #(.W(W)) u_core (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .op_i  (op_i),
    .a_i   (a_i),
    .b_i   (b_i),
    .c_i   (status_o[F_C]),
    .ac_i  (status_o[F_AC]),
    .res_o (res_o),
    .flg_o (flg),
    .upd_o (upd)
  );

  alu_status_reg u_stat (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .exec_i     (exec_i),
    .flg_i      (flg),
    .upd_i      (upd),
    .sw_wr_i    (sw_wr_i),
    .sw_flags_i (sw_flags_i),
    .pwrup_i    (pwrup_i),
    .clrwdt_i   (clrwdt_i),
    .halt_i     (halt_i),
    .wdto_i     (wdto_i),
    .status_o   (status_o)
  );

endmodule

// File: tb/sim_alu_status_unit.sv
module sim_alu_status_unit;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       exec_i;
  logic [3:0] op_i;
  logic [7:0] a_i, b_i;
  logic [7:0] res_o;
  logic [7:0] status_o;
  logic       sw_wr_i;
  logic [3:0] sw_flags_i;
  logic       pwrup_i, clrwdt_i, halt_i, wdto_i;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  alu_status_unit #(.W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .res_o(res_o), .status_o(status_o), .sw_wr_i(sw_wr_i), .sw_flags_i(sw_flags_i),
    .pwrup_i(pwrup_i), .clrwdt_i(clrwdt_i), .halt_i(halt_i), .wdto_i(wdto_i)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int sgn(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // returns {flags[3:0], result[7:0]}
  function automatic int model(input int op, input int a, input int b, input int p);
    int r, f, c, ac, cc, bo, sr, lo, hi;
    f = p; c = p & 1; ac = (p >> 1) & 1; r = a;
    case (op)
      0, 1: begin
        cc = (op == 1) ? c : 0;
        r = a + b + cc;
        sr = sgn(a) + sgn(b) + cc;
        f = (r > 255) | ((((a % 16) + (b % 16) + cc) > 15) << 1) | (((sr > 127) || (sr < -128)) << 3);
        r = r % 256;
        f = f | ((r == 0) << 2);
      end
      2, 3: begin
        bo = (op == 3) ? 1 - c : 0;
        r = a - b - bo;
        sr = sgn(a) - sgn(b) - bo;
        f = int'(r >= 0) | ((((a % 16) - (b % 16) - bo) >= 0) << 1) | (((sr > 127) || (sr < -128)) << 3);
        r = (r + 256) % 256;
        f = f | ((r == 0) << 2);
      end
      4: begin
        lo = a % 16;
        if (lo > 9 || ac == 1) lo = lo + 6;
        hi = a / 16 + lo / 16;
        if (hi > 9 || c == 1) hi = hi + 6;
        r = (hi % 16) * 16 + (lo % 16);
        f = (p & 14) | ((hi > 15) ? 1 : c);
      end
      5, 6, 7, 8, 13, 14: begin
        if (op == 5) r = a & b;
        if (op == 6) r = a | b;
        if (op == 7) r = a ^ b;
        if (op == 8) r = 255 - a;
        if (op == 13) r = (a + 1) % 256;
        if (op == 14) r = (a + 255) % 256;
        f = (p & 11) | ((r == 0) << 2);
      end
      9:  r = ((a * 2) % 256) + a / 128;
      10: r = a / 2 + (a % 2) * 128;
      11: begin r = ((a * 2) % 256) + c; f = (p & 14) | (a / 128); end
      12: begin r = a / 2 + c * 128;     f = (p & 14) | (a % 2); end
      default: r = a;
    endcase
    return (f << 8) | r;
  endfunction

  // called at a negedge, returns at a negedge
  task automatic do_op(input int op, input int a, input int b, input int p, input string req);
    int e;
    e = model(op, a, b, p);
    sw_wr_i = 1'b1; sw_flags_i = p[3:0];
    @(negedge clk);
    sw_wr_i = 1'b0; exec_i = 1'b1;
    op_i = op[3:0]; a_i = a[7:0]; b_i = b[7:0];
    #1;
    chk({req, " result"}, int'(res_o), e & 255);
    @(negedge clk);
    exec_i = 1'b0;
    chk({req, " flags"}, int'(status_o), e >> 8);
  endtask

  task automatic ev(input bit pw, input bit cw, input bit hl, input bit wt,
                    input int exp, input string req);
    pwrup_i = pw; clrwdt_i = cw; halt_i = hl; wdto_i = wt;
    @(negedge clk);
    pwrup_i = 0; clrwdt_i = 0; halt_i = 0; wdto_i = 0;
    chk(req, int'(status_o), exp);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; exec_i = 0; op_i = 0; a_i = 0; b_i = 0; sw_wr_i = 0; sw_flags_i = 0;
    pwrup_i = 0; clrwdt_i = 0; halt_i = 0; wdto_i = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset value", int'(status_o), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 after release", int'(status_o), 0);

    // R1/R9: all writable bits set, upper bits stay 0
    sw_wr_i = 1; sw_flags_i = 4'hF;
    @(negedge clk); sw_wr_i = 0;
    chk("R1 R9 write all ones", int'(status_o), 8'h0F);

    ev(0, 0, 1, 0, 8'h1F, "R10 halt sets power-down");
    sw_wr_i = 1; sw_flags_i = 4'h0;
    @(negedge clk); sw_wr_i = 0;
    chk("R9 write leaves power flags", int'(status_o), 8'h10);
    ev(0, 0, 0, 1, 8'h30, "R11 expiry sets");
    ev(0, 0, 1, 0, 8'h10, "R11 halt clears expiry");
    ev(0, 0, 1, 1, 8'h30, "R11 expiry beats halt");
    ev(0, 1, 0, 0, 8'h00, "R10 clear resets both");
    ev(0, 1, 1, 0, 8'h00, "R10 clear beats halt");
    ev(0, 0, 1, 0, 8'h10, "R10 halt again");
    ev(0, 0, 0, 1, 8'h30, "R11 expiry again");
    ev(1, 0, 1, 1, 8'h00, "R12 power-up beats all");

    // R8: no execute, no flag change; result still combinational
    sw_wr_i = 1; sw_flags_i = 4'h5;
    @(negedge clk); sw_wr_i = 0;
    op_i = 4'd0; a_i = 8'hFF; b_i = 8'h01; exec_i = 0;
    #1 chk("R8 result without execute", int'(res_o), 8'h00);
    @(negedge clk);
    chk("R8 flags held", int'(status_o), 8'h05);

    // R9: software write beats execute in the same cycle
    sw_wr_i = 1; sw_flags_i = 4'hA; exec_i = 1;
    @(negedge clk); sw_wr_i = 0; exec_i = 0;
    chk("R9 write beats execute", int'(status_o), 8'h0A);

    // Sweeps
    for (int a = 0; a < 256; a++) begin
      for (int k = 0; k < 32; k++) begin
        int b;
        int p;
        b = (k * 8 + (k % 8)) % 256;
        p = ((a >> 2) & 1) << 3 | ((b >> 3) & 1) << 2 | (k % 2) << 1;
        do_op(0, a, b, p, "R2 R4 add");
        do_op(2, a, b, p, "R3 R4 subtract");
        do_op(1, a, b, p, "R2 R4 add carry0");
        do_op(1, a, b, p | 1, "R2 R4 add carry1");
        do_op(3, a, b, p, "R3 R4 subtract carry0");
        do_op(3, a, b, p | 1, "R3 R4 subtract carry1");
      end
      for (int k = 0; k < 8; k++) begin
        int b;
        b = (k * 37 + 3) % 256;
        if (k == 0) b = 0;
        if (k == 1) b = 255;
        do_op(5, a, b, k % 16, "R6 and");
        do_op(6, a, b, (k + 5) % 16, "R6 or");
        do_op(7, a, b, (k + 9) % 16, "R6 xor");
      end
      for (int p = 0; p < 4; p++) begin
        do_op(4, a, 0, p | 8, "R5 decimal adjust");
      end
      do_op(8,  a, 0, 4'hB, "R6 complement");
      do_op(13, a, 0, 4'h3, "R6 increment");
      do_op(14, a, 0, 4'hA, "R6 decrement");
      do_op(9,  a, 0, 4'h5, "R7 rotate left");
      do_op(10, a, 0, 4'hA, "R7 rotate right");
      do_op(11, a, 0, 4'h4, "R7 rotate left carry0");
      do_op(11, a, 0, 4'hB, "R7 rotate left carry1");
      do_op(12, a, 0, 4'h2, "R7 rotate right carry0");
      do_op(12, a, 0, 4'hD, "R7 rotate right carry1");
      do_op(15, a, 7, 4'h9, "R7 pass");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule